// File: doc/BRIEF.md
# Interrupt Pending Register with Atomic Updates

This block holds the pending-interrupt state of a small microcontroller interrupt controller. It has one bit per source. A one-cycle strobe from a peripheral sets that source's bit. Software, through a CPU-side port, can replace the whole register, AND it with a mask, or OR it with a mask, each as one single-cycle command. An acknowledge from the CPU clears the bit that was serviced.

Each source has its own enable, and there is also one global enable. If a source is enabled, its bit is pending and the global enable is on, the block raises its request line to the CPU. If the global enable is off, no request goes to the CPU, but the pending bits stay visible for polling. The block also reports the index of the lowest-numbered pending bit that is enabled.

Hardware strobes always take priority over software and acknowledge updates in the same cycle. This means a masked clear or set done by software can never lose a request that arrives at that moment.

Top module: `irq_pending_reg`

## Requirements
- R1: A strobe on `hw_req[i]` makes `pending[i]` read 1 after the next rising clock edge.
- R2: With `sw_op` = 2'b01 (load), `pending` becomes `sw_data`. A 1 loaded this way raises `cpu_irq` exactly as a hardware strobe would when that source is enabled.
- R3: With `sw_op` = 2'b10 (AND), `pending` becomes `pending & sw_data`, and any `hw_req` bit active in the same cycle is still set afterwards.
- R4: With `sw_op` = 2'b11 (OR), `pending` becomes `pending | sw_data`, and same-cycle `hw_req` bits are also set.
- R5: During a load (2'b01), a bit whose `hw_req` is active in the same cycle ends at 1, whatever `sw_data` holds.
- R6: With `ack_valid` high, bit `ack_idx` clears. The clear is applied after the software operation; `sw_op` = 2'b00 means no software operation.
- R7: When an acknowledge and a hardware strobe hit the same bit in the same cycle, that bit stays 1.
- R8: `cpu_irq` equals `global_en` AND the OR over all bits of (`pending` & `irq_en`). It is registered and is updated at the same edge as `pending`, using the enables sampled at that edge.
- R9: While `global_en` is low, `cpu_irq` is 0, and `pending` still updates and can be read.
- R10: `sel_idx` is the lowest-numbered bit of (`pending` & `irq_en`), and `sel_valid` is 1 when that set is not empty. When the set is empty, `sel_idx` reads 0 and `sel_valid` reads 0. This output is independent of `global_en`.
- R11: A synchronous active-high `rst` clears `pending`, `cpu_irq`, `sel_idx` and `sel_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | NUM_SRC | Peripheral request strobes, one per source |
| sw_op | input | 2 | Software command: 00 none, 01 load, 10 AND, 11 OR |
| sw_data | input | NUM_SRC | Data or mask for the software command |
| ack_valid | input | 1 | CPU acknowledge strobe |
| ack_idx | input | IDX_W | Index of the acknowledged source |
| irq_en | input | NUM_SRC | Per-source enables |
| global_en | input | 1 | Global interrupt enable |
| pending | output | NUM_SRC | Pending register contents |
| sel_idx | output | IDX_W | Lowest enabled pending index |
| sel_valid | output | 1 | An enabled bit is pending |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The assertions assume that the inputs are stable around each rising edge. They also assume that `ack_idx` is only meaningful while `ack_valid` is high. Past-value properties are qualified by a flag that shows the previous edge was not in reset, so values held during reset never count as history. The stimulus changes inputs only on falling edges and reads outputs one nanosecond after a rising edge. Every `ack_idx` it uses is below `NUM_SRC`.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_LOAD = 2'b01,
    OP_AND  = 2'b10,
    OP_OR   = 2'b11
  } sw_op_e;
endpackage

// File: rtl/irqp_ack_decode.sv
module irqp_ack_decode #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               ack_valid,
  input  logic [IDX_W-1:0]   ack_idx,
  output logic [NUM_SRC-1:0] ack_mask
);
  // One-hot clear mask, one comparator per source.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
    assign ack_mask[g] = ack_valid && (ack_idx == IDX_W'(g));
  end
endmodule

// File: rtl/irqp_next_state.sv
module irqp_next_state
  import irqp_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] cur,
  input  logic [1:0]         sw_op,
  input  logic [NUM_SRC-1:0] sw_data,
  input  logic [NUM_SRC-1:0] ack_mask,
  input  logic [NUM_SRC-1:0] hw_req,
  output logic [NUM_SRC-1:0] nxt
);
  logic [NUM_SRC-1:0] after_op;

  always_comb begin
    unique case (sw_op_e'(sw_op))
      OP_LOAD: after_op = sw_data;
      OP_AND:  after_op = cur & sw_data;
      OP_OR:   after_op = cur | sw_data;
      default: after_op = cur;
    endcase
    // Order: software op, then acknowledge clear, then hardware sets win.
    nxt = (after_op & ~ack_mask) | hw_req;
  end
endmodule

// File: rtl/irqp_lowest_sel.sv
module irqp_lowest_sel #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] cand,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg
  import irqp_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] hw_req,
  input  logic [1:0]         sw_op,
  input  logic [NUM_SRC-1:0] sw_data,
  input  logic               ack_valid,
  input  logic [IDX_W-1:0]   ack_idx,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               global_en,
  output logic [NUM_SRC-1:0] pending,
  output logic [IDX_W-1:0]   sel_idx,
  output logic               sel_valid,
  output logic               cpu_irq
);
  logic [NUM_SRC-1:0] ack_mask;
  logic [NUM_SRC-1:0] pend_nxt;
  logic [NUM_SRC-1:0] pend_q;
  logic [IDX_W-1:0]   sel_nxt;
  logic               any_nxt;
  logic [IDX_W-1:0]   sel_q;
  logic               selv_q;
  logic               irq_q;
  logic               past_ok;

  irqp_ack_decode #(.NUM_SRC(NUM_SRC)) u_dec (
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .ack_mask  (ack_mask)
  );

  irqp_next_state #(.NUM_SRC(NUM_SRC)) u_nxt (
    .cur      (pend_q),
    .sw_op    (sw_op),
    .sw_data  (sw_data),
    .ack_mask (ack_mask),
    .hw_req   (hw_req),
    .nxt      (pend_nxt)
  );

  // Selection looks at the next state so all outputs move together.
  irqp_lowest_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .cand (pend_nxt & irq_en),
    .idx  (sel_nxt),
    .any  (any_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      sel_q   <= '0;
      selv_q  <= 1'b0;
      irq_q   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      pend_q  <= pend_nxt;
      sel_q   <= sel_nxt;
      selv_q  <= any_nxt;
      irq_q   <= global_en && any_nxt;
      past_ok <= 1'b1;
    end
  end

  assign pending   = pend_q;
  assign sel_idx   = sel_q;
  assign sel_valid = selv_q;
  assign cpu_irq   = irq_q;

  assert_hw_sets_R1: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((pend_q & $past(hw_req)) == $past(hw_req)));

  assert_or_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(sw_op == 2'b11 && !ack_valid))
      |-> ((pend_q & $past(pend_q | sw_data)) == $past(pend_q | sw_data)));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(ack_valid && sw_op == 2'b00 && !hw_req[ack_idx]))
      |-> !pend_q[$past(ack_idx)]);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (irq_q == ($past(global_en) && |(pend_q & $past(irq_en)))));

  assert_sel_pending_R10: assert property (@(posedge clk) disable iff (rst)
    selv_q |-> pend_q[sel_q]);
endmodule

// File: tb/sim_irq_pending_reg.sv
module sim_irq_pending_reg;
  localparam int N = 8;
  localparam int IW = 3;
  localparam int NV = 12;

  typedef struct packed {
    logic [7:0] hw;
    logic [1:0] op;
    logic [7:0] data;
    logic       ackv;
    logic [2:0] acki;
    logic [7:0] en;
    logic       gen;
    logic [7:0] expp;
  } vec_t;

  // Each row: stimulus, then the expected pending value after the edge.
  localparam vec_t VEC [NV] = '{
    '{8'h05, 2'b00, 8'h00, 1'b0, 3'd0, 8'hFF, 1'b1, 8'h05}, // R1
    '{8'h00, 2'b11, 8'h80, 1'b0, 3'd0, 8'hFF, 1'b1, 8'h85}, // R4
    '{8'h02, 2'b10, 8'hFE, 1'b0, 3'd0, 8'hFF, 1'b1, 8'h86}, // R3
    '{8'h10, 2'b01, 8'h01, 1'b0, 3'd0, 8'hFF, 1'b1, 8'h11}, // R5 R2
    '{8'h00, 2'b00, 8'h00, 1'b1, 3'd0, 8'hFF, 1'b1, 8'h10}, // R6
    '{8'h10, 2'b00, 8'h00, 1'b1, 3'd4, 8'hFF, 1'b1, 8'h10}, // R7
    '{8'h00, 2'b00, 8'h00, 1'b1, 3'd4, 8'hFF, 1'b1, 8'h00}, // R6
    '{8'h00, 2'b01, 8'h40, 1'b0, 3'd0, 8'h00, 1'b1, 8'h40}, // R2 R10
    '{8'h08, 2'b00, 8'h00, 1'b0, 3'd0, 8'h08, 1'b0, 8'h48}, // R9
    '{8'h00, 2'b10, 8'h00, 1'b0, 3'd0, 8'hFF, 1'b1, 8'h00}, // R3
    '{8'h01, 2'b11, 8'h30, 1'b0, 3'd0, 8'hFF, 1'b1, 8'h31}, // R4
    '{8'h00, 2'b10, 8'hFF, 1'b1, 3'd0, 8'hFF, 1'b1, 8'h30}  // R6
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  hw_req = '0;
  logic [1:0]    sw_op = 2'b00;
  logic [N-1:0]  sw_data = '0;
  logic          ack_valid = 1'b0;
  logic [IW-1:0] ack_idx = '0;
  logic [N-1:0]  irq_en = '0;
  logic          global_en = 1'b0;
  logic [N-1:0]  pending;
  logic [IW-1:0] sel_idx;
  logic          sel_valid;
  logic          cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_pending_reg #(.NUM_SRC(N)) u0 (
    .clk(clk), .rst(rst), .hw_req(hw_req), .sw_op(sw_op), .sw_data(sw_data),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .irq_en(irq_en),
    .global_en(global_en), .pending(pending), .sel_idx(sel_idx),
    .sel_valid(sel_valid), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 ns after the rising edge.
  task automatic step(input logic [7:0] hw, input logic [1:0] op, input logic [7:0] d,
                      input logic av, input logic [2:0] ai, input logic [7:0] en,
                      input logic ge);
    @(negedge clk);
    hw_req = hw; sw_op = op; sw_data = d; ack_valid = av; ack_idx = ai;
    irq_en = en; global_en = ge;
    @(posedge clk);
    #1;
  endtask

  task automatic check_outputs(input string tag, input logic [7:0] expp,
                               input logic [7:0] en, input logic ge);
    logic [7:0] cand;
    logic [2:0] ei;
    logic       ev;
    cand = expp & en;
    ei = '0;
    ev = 1'b0;
    for (int i = N - 1; i >= 0; i--) if (cand[i]) begin ei = 3'(i); ev = 1'b1; end
    chk({tag, " pending"}, pending, expp);
    chk({tag, " R8 R9 cpu_irq"}, {7'b0, cpu_irq}, {7'b0, ge & ev});
    chk({tag, " R10 sel_valid"}, {7'b0, sel_valid}, {7'b0, ev});
    chk({tag, " R10 sel_idx"}, {5'b0, sel_idx}, {5'b0, ei});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: state after reset
    chk("R11 pending", pending, 8'h00);
    chk("R11 cpu_irq", {7'b0, cpu_irq}, 8'h00);
    chk("R11 sel", {4'b0, sel_valid, sel_idx}, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      step(VEC[v].hw, VEC[v].op, VEC[v].data, VEC[v].ackv, VEC[v].acki,
           VEC[v].en, VEC[v].gen);
      check_outputs($sformatf("vec%0d", v), VEC[v].expp, VEC[v].en, VEC[v].gen);
    end

    // R10: lowest of several enabled bits, bit 0 masked off
    step(8'hA1, 2'b00, 8'h00, 1'b0, 3'd0, 8'hFE, 1'b1);
    check_outputs("R10 lowest", 8'hB1, 8'hFE, 1'b1);
    // R2: software-loaded bit alone raises cpu_irq
    step(8'h00, 2'b01, 8'h04, 1'b0, 3'd0, 8'h04, 1'b1);
    check_outputs("R2 load irq", 8'h04, 8'h04, 1'b1);
    // R8: same pending, enable dropped -> no irq
    step(8'h00, 2'b00, 8'h00, 1'b0, 3'd0, 8'hFB, 1'b1);
    check_outputs("R8 enable off", 8'h04, 8'hFB, 1'b1);
    // R5: load of zeros with all strobes active keeps all ones
    step(8'hFF, 2'b01, 8'h00, 1'b0, 3'd0, 8'hFF, 1'b0);
    check_outputs("R5 load vs hw", 8'hFF, 8'hFF, 1'b0);
    // R7: AND clear plus ack plus strobe on bit 7
    step(8'h80, 2'b10, 8'h00, 1'b1, 3'd7, 8'hFF, 1'b1);
    check_outputs("R7 ack vs hw", 8'h80, 8'hFF, 1'b1);

    // R11: reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    hw_req = '0; sw_op = 2'b00; ack_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R11 mid pending", pending, 8'h00);
    chk("R11 mid irq", {7'b0, cpu_irq}, 8'h00);
    chk("R11 mid sel", {4'b0, sel_valid, sel_idx}, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule